// File: doc/BRIEF.md
# Set-Associative Data Cache with Bulk Message-Line Invalidate

This block is a small first-level data cache with four ways per set and a blocking miss path. Every line carries a type bit that marks it as holding message data rather than ordinary memory data. The bit is copied from the per-access attribute input `req_msg` at the moment the line is installed. The address-translation path drives that input alongside each request. Each write chooses its own policy. A write-back write updates only the cache and marks the line dirty. A write-through write always goes to memory, and when it misses it does not allocate a line.

The strobe `inv_msg` drops, within one clock edge, the valid and dirty state of every line whose type bit is set. Lines with a clear type bit are left as they are. Dirty message lines are discarded and are not written back, so software flushes them before it raises the strobe. After the strobe, every access to an address that a message line held misses and goes to memory. This lets software manage coherence for shared message buffers without a hardware protocol.

The memory side uses a plain request/acknowledge handshake with one word per line. A miss that evicts a dirty victim first writes the victim back and then fills the new line. Replacement fills invalid ways first, lowest index first, and otherwise follows a three-bit tree pseudo-LRU per set.

Top module: `msg_cache`

## Requirements
- R1: Four distinct addresses that share a set index all stay resident together: once each has been filled, reading any of them again hits.
- R2: A read miss fetches the word from memory and returns it. A read hit returns the stored word with `resp_valid` high in the cycle after acceptance and causes no memory read.
- R3: A write-back write that hits updates only the cache and causes no memory traffic. A write-back write that misses fills the line and then merges the data. When a dirty victim is replaced, it is written to memory before the fill read.
- R4: A write-through write always performs exactly one memory write. On a hit it also updates the cached copy. On a miss it allocates nothing, so a later read of that address misses.
- R5: The type bit of a line is taken from `req_msg` of the access that installs it. A line installed with `req_msg`=1 is affected by the bulk invalidate, and a line installed with `req_msg`=0 is not.
- R6: One cycle of `inv_msg` high makes every line with the type bit set invalid at the next clock edge, and any later access to such an address misses.
- R7: Across a bulk invalidate, lines with a clear type bit keep their valid bit, their data and their dirty bit, so a dirty one is still written back when it is later evicted.
- R8: A bulk invalidate generates no memory write. The data of a dirty message line is lost, and a later read returns the memory copy.
- R9: The victim is the lowest-numbered invalid way when one exists. Otherwise the tree pseudo-LRU picks it: bit 0 chooses the half (1 means ways 2/3), bit 1 chooses between ways 0 and 1, and bit 2 chooses between ways 2 and 3. Each access points the bits away from the way it touched.
- R10: If `inv_msg` is high in the same cycle that a fill completes, the read data is still returned. A line filled with `req_msg`=1 then ends up invalid, while a line filled with `req_msg`=0 stays valid.
- R11: While a memory access is pending, `mem_req` stays high with a stable address and direction until `mem_ack`, and `req_ready` stays low.
- R12: After reset the cache holds no valid line, `req_ready` is high, and `resp_valid` and `mem_req` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Core request present |
| req_ready | output | 1 | Cache can accept a request this cycle |
| req_we | input | 1 | 1 = write, 0 = read |
| req_wback | input | 1 | For writes: 1 = write-back, 0 = write-through |
| req_msg | input | 1 | Page attribute: 1 = message data |
| req_addr | input | ADDR_W | Word address; low bits select the set |
| req_wdata | input | DATA_W | Write data |
| resp_valid | output | 1 | One-cycle completion pulse |
| resp_rdata | output | DATA_W | Read data, valid with resp_valid |
| inv_msg | input | 1 | Bulk invalidate of message lines |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = memory write |
| mem_addr | output | ADDR_W | Memory word address |
| mem_wdata | output | DATA_W | Memory write data |
| mem_ack | input | 1 | Memory completes the access this cycle |
| mem_rdata | input | DATA_W | Memory read data, valid with mem_ack |

## Verification
A stale type bit or valid bit shows up at the ports on the first access to the affected address after the strobe. Where a miss was expected the memory read count stays flat, or a hit turns into a memory read. A wrong dirty bit becomes visible only later, as a missing or extra memory write when that line is evicted. For that reason the checks force evictions through a deterministic sequence of the replacement tree and compare the memory traffic, access by access. A wrong pseudo-LRU state appears as a hit or miss on the wrong address within one or two accesses of the eviction it misdirected.

// File: rtl/mcache_pkg.sv
package mcache_pkg;

    localparam int WAYS  = 4;
    localparam int WAY_W = 2;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_EVICT = 2'd1,
        ST_FILL  = 2'd2,
        ST_WTHRU = 2'd3
    } cache_st_e;

    // Point the tree away from the way just used.
    function automatic logic [2:0] plru_touch(input logic [2:0] tree, input logic [WAY_W-1:0] way);
        logic [2:0] r;
        r    = tree;
        r[0] = ~way[1];
        if (!way[1]) r[1] = ~way[0];
        else         r[2] = ~way[0];
        return r;
    endfunction

endpackage

// File: rtl/mcache_match.sv
module mcache_match
    import mcache_pkg::*;
#(
    parameter int TAG_W = 8
) (
    input  logic [WAYS-1:0]            vld,
    input  logic [WAYS-1:0][TAG_W-1:0] tags,
    input  logic [TAG_W-1:0]           tag,
    output logic                       hit,
    output logic [WAY_W-1:0]           way
);

    logic [WAYS-1:0] eq;

    for (genvar g = 0; g < WAYS; g++) begin : g_cmp
        assign eq[g] = vld[g] && (tags[g] == tag);
    end

    always_comb begin
        hit = |eq;
        way = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (eq[w]) way = WAY_W'(w);
        end
    end

endmodule

// File: rtl/mcache_victim.sv
module mcache_victim
    import mcache_pkg::*;
(
    input  logic [2:0]       tree,
    input  logic [WAYS-1:0]  vld,
    output logic [WAY_W-1:0] way
);

    always_comb begin
        way = tree[0] ? {1'b1, tree[2]} : {1'b0, tree[1]};
        // Descending scan leaves the lowest invalid way selected.
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (!vld[w]) way = WAY_W'(w);
        end
    end

endmodule

// File: rtl/msg_cache.sv
module msg_cache
    import mcache_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32,
    parameter int SETS   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_we,
    input  logic              req_wback,
    input  logic              req_msg,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              resp_valid,
    output logic [DATA_W-1:0] resp_rdata,
    input  logic              inv_msg,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic              mem_ack,
    input  logic [DATA_W-1:0] mem_rdata
);

    localparam int IDX_W = $clog2(SETS);
    localparam int TAG_W = ADDR_W - IDX_W;

    typedef struct packed {
        logic              vld;
        logic              dty;
        logic              msg;
        logic [TAG_W-1:0]  tag;
        logic [DATA_W-1:0] data;
    } line_t;

    typedef struct packed {
        cache_st_e                     st;
        line_t [SETS-1:0][WAYS-1:0]    lines;
        logic  [SETS-1:0][2:0]         plru;
        logic  [ADDR_W-1:0]            addr;
        logic  [DATA_W-1:0]            wdata;
        logic                          we;
        logic                          wb;
        logic                          msg;
        logic  [WAY_W-1:0]             way;
        logic                          resp;
        logic  [DATA_W-1:0]            rdata;
    } state_t;

    state_t d, q;

    logic [IDX_W-1:0]            rset;
    logic [TAG_W-1:0]            rtag;
    logic [IDX_W-1:0]            qset;
    logic [TAG_W-1:0]            qtag;
    logic [WAYS-1:0]             set_vld;
    logic [WAYS-1:0][TAG_W-1:0]  set_tag;
    logic                        hit;
    logic [WAY_W-1:0]            hit_way;
    logic [WAY_W-1:0]            vic_way;

    // Observation of line state for the bound checker.
    logic [SETS*WAYS-1:0]        tagged_live;
    logic [2*SETS*WAYS-1:0]      untagged_state;

    assign rset = req_addr[IDX_W-1:0];
    assign rtag = req_addr[ADDR_W-1:IDX_W];
    assign qset = q.addr[IDX_W-1:0];
    assign qtag = q.addr[ADDR_W-1:IDX_W];

    always_comb begin
        for (int w = 0; w < WAYS; w++) begin
            set_vld[w] = q.lines[rset][w].vld;
            set_tag[w] = q.lines[rset][w].tag;
        end
    end

    mcache_match #(.TAG_W(TAG_W)) u_match (
        .vld  (set_vld),
        .tags (set_tag),
        .tag  (rtag),
        .hit  (hit),
        .way  (hit_way)
    );

    mcache_victim u_victim (
        .tree (q.plru[rset]),
        .vld  (set_vld),
        .way  (vic_way)
    );

    always_comb begin
        d         = q;
        d.resp    = 1'b0;
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = q.addr;
        mem_wdata = q.wdata;

        unique case (q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    d.addr  = req_addr;
                    d.wdata = req_wdata;
                    d.we    = req_we;
                    d.wb    = req_wback;
                    d.msg   = req_msg;
                    if (hit) begin
                        d.plru[rset] = plru_touch(q.plru[rset], hit_way);
                        if (!req_we) begin
                            d.resp  = 1'b1;
                            d.rdata = q.lines[rset][hit_way].data;
                        end else begin
                            d.lines[rset][hit_way].data = req_wdata;
                            if (req_wback) begin
                                d.lines[rset][hit_way].dty = 1'b1;
                                d.resp = 1'b1;
                            end else begin
                                d.st = ST_WTHRU;
                            end
                        end
                    end else if (req_we && !req_wback) begin
                        d.st = ST_WTHRU;
                    end else begin
                        d.way = vic_way;
                        if (q.lines[rset][vic_way].vld && q.lines[rset][vic_way].dty)
                            d.st = ST_EVICT;
                        else
                            d.st = ST_FILL;
                    end
                end
            end
            ST_EVICT: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = {q.lines[qset][q.way].tag, qset};
                mem_wdata = q.lines[qset][q.way].data;
                if (mem_ack) d.st = ST_FILL;
            end
            ST_FILL: begin
                mem_req = 1'b1;
                if (mem_ack) begin
                    d.lines[qset][q.way].vld  = 1'b1;
                    d.lines[qset][q.way].dty  = q.we;
                    d.lines[qset][q.way].msg  = q.msg;
                    d.lines[qset][q.way].tag  = qtag;
                    d.lines[qset][q.way].data = q.we ? q.wdata : mem_rdata;
                    d.plru[qset] = plru_touch(q.plru[qset], q.way);
                    d.resp  = 1'b1;
                    d.rdata = mem_rdata;
                    d.st    = ST_IDLE;
                end
            end
            ST_WTHRU: begin
                mem_req = 1'b1;
                mem_we  = 1'b1;
                if (mem_ack) begin
                    d.resp = 1'b1;
                    d.st   = ST_IDLE;
                end
            end
            default: d.st = ST_IDLE;
        endcase

        // Bulk invalidate overrides every update made above in this cycle.
        if (inv_msg) begin
            for (int s = 0; s < SETS; s++) begin
                for (int w = 0; w < WAYS; w++) begin
                    if (d.lines[s][w].msg) begin
                        d.lines[s][w].vld = 1'b0;
                        d.lines[s][w].dty = 1'b0;
                    end
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_comb begin
        for (int s = 0; s < SETS; s++) begin
            for (int w = 0; w < WAYS; w++) begin
                tagged_live[s*WAYS+w] = q.lines[s][w].vld && q.lines[s][w].msg;
                untagged_state[2*(s*WAYS+w)]   = q.lines[s][w].vld && !q.lines[s][w].msg;
                untagged_state[2*(s*WAYS+w)+1] = q.lines[s][w].dty && !q.lines[s][w].msg;
            end
        end
    end

    assign req_ready  = (q.st == ST_IDLE);
    assign resp_valid = q.resp;
    assign resp_rdata = q.rdata;

endmodule

// File: rtl/msg_cache_chk.sv
module msg_cache_chk
    import mcache_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int SETS   = 8
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    req_valid,
    input logic                    req_ready,
    input logic                    inv_msg,
    input logic                    resp_valid,
    input logic                    mem_req,
    input logic                    mem_we,
    input logic                    mem_ack,
    input logic [ADDR_W-1:0]       mem_addr,
    input logic [SETS*WAYS-1:0]    tagged_live,
    input logic [2*SETS*WAYS-1:0]  untagged_state
);

    a_r6_tagged_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        inv_msg |=> (tagged_live == '0));

    a_r7_untagged_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (inv_msg && req_ready && !req_valid) |=> (untagged_state == $past(untagged_state)));

    a_r2_fill_responds: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_ack && !mem_we) |=> resp_valid);

    a_r11_mem_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

    a_r11_busy: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> !req_ready);

endmodule

bind msg_cache msg_cache_chk #(.ADDR_W(ADDR_W), .SETS(SETS)) u_chk (.*);

// File: tb/msg_cache_tb.sv
`timescale 1ns/1ps
module msg_cache_tb;

    localparam int AW = 10;
    localparam int DW = 32;
    localparam int NV = 24;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0, req_we = 1'b0, req_wback = 1'b0, req_msg = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic          req_ready, resp_valid;
    logic [DW-1:0] resp_rdata;
    logic          inv_task = 1'b0, inv_auto, arm_inv = 1'b0;
    logic          inv_msg;
    logic          mem_req, mem_we, mem_ack;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_wdata, mem_rdata;

    logic [DW-1:0] mem [1 << AW];
    int nrd, nwr;
    int checks = 0, errors = 0, cyc = 0;

    assign inv_msg = inv_task | inv_auto;

    always #2.5 clk = ~clk;

    msg_cache #(.ADDR_W(AW), .DATA_W(DW), .SETS(8)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_we(req_we), .req_wback(req_wback), .req_msg(req_msg),
        .req_addr(req_addr), .req_wdata(req_wdata), .resp_valid(resp_valid),
        .resp_rdata(resp_rdata), .inv_msg(inv_msg), .mem_req(mem_req),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata)
    );

    // Memory model: acknowledges one cycle after a request appears.
    always @(negedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < (1 << AW); i++) mem[i] = 32'hC0DE0000 | i;
            nrd <= 0; nwr <= 0; mem_ack <= 1'b0; inv_auto <= 1'b0; mem_rdata <= '0;
        end else begin
            mem_ack  <= 1'b0;
            inv_auto <= 1'b0;
            if (mem_req && !mem_ack) begin
                mem_ack <= 1'b1;
                if (mem_we) begin
                    mem[mem_addr] = mem_wdata;
                    nwr <= nwr + 1;
                end else begin
                    mem_rdata <= mem[mem_addr];
                    nrd <= nrd + 1;
                    inv_auto <= arm_inv;
                end
            end
        end
    end

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 50000) begin
            checks++; errors++;
            $display("FAIL R11 watchdog: actual cycles=%0d expected below 50000", cyc);
            summary();
            $finish;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic access(input logic we, input logic wb, input logic msg,
                          input logic [AW-1:0] a, input logic [DW-1:0] wd,
                          output logic [DW-1:0] rd, output int lat, output logic busy);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_we = we; req_wback = wb; req_msg = msg;
        req_addr = a; req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0;
        busy = !req_ready;
        lat = 1;
        while (!resp_valid && lat < 200) begin
            @(negedge clk);
            lat++;
        end
        rd = resp_rdata;
    endtask

    task automatic pulse_inv();
        inv_task = 1'b1;
        @(negedge clk);
        inv_task = 1'b0;
    endtask

    typedef struct packed {
        logic          we;
        logic          wb;
        logic          msg;
        logic [AW-1:0] addr;
        logic [31:0]   wdata;
        logic [31:0]   exp;
        logic [1:0]    drd;
        logic [1:0]    dwr;
    } vec_t;

    // Set 1 walk: fills, hits, pseudo-LRU evictions, dirty write-back; then sets 2 and 3.
    localparam vec_t VEC [NV] = '{
        '{1'b0, 1'b0, 1'b0, 10'h001, 32'h0,        32'hC0DE0001, 2'd1, 2'd0},
        '{1'b0, 1'b0, 1'b0, 10'h001, 32'h0,        32'hC0DE0001, 2'd0, 2'd0},
        '{1'b0, 1'b0, 1'b0, 10'h009, 32'h0,        32'hC0DE0009, 2'd1, 2'd0},
        '{1'b0, 1'b0, 1'b0, 10'h011, 32'h0,        32'hC0DE0011, 2'd1, 2'd0},
        '{1'b0, 1'b0, 1'b0, 10'h019, 32'h0,        32'hC0DE0019, 2'd1, 2'd0},
        '{1'b0, 1'b0, 1'b0, 10'h001, 32'h0,        32'hC0DE0001, 2'd0, 2'd0},
        '{1'b0, 1'b0, 1'b0, 10'h009, 32'h0,        32'hC0DE0009, 2'd0, 2'd0},
        '{1'b0, 1'b0, 1'b0, 10'h011, 32'h0,        32'hC0DE0011, 2'd0, 2'd0},
        '{1'b0, 1'b0, 1'b0, 10'h019, 32'h0,        32'hC0DE0019, 2'd0, 2'd0},
        '{1'b1, 1'b1, 1'b0, 10'h009, 32'h11110009, 32'h0,        2'd0, 2'd0},
        '{1'b0, 1'b0, 1'b0, 10'h021, 32'h0,        32'hC0DE0021, 2'd1, 2'd0},
        '{1'b0, 1'b0, 1'b0, 10'h011, 32'h0,        32'hC0DE0011, 2'd1, 2'd0},
        '{1'b0, 1'b0, 1'b0, 10'h009, 32'h0,        32'h11110009, 2'd0, 2'd0},
        '{1'b0, 1'b0, 1'b0, 10'h001, 32'h0,        32'hC0DE0001, 2'd1, 2'd0},
        '{1'b0, 1'b0, 1'b0, 10'h031, 32'h0,        32'hC0DE0031, 2'd1, 2'd0},
        '{1'b0, 1'b0, 1'b0, 10'h039, 32'h0,        32'hC0DE0039, 2'd1, 2'd0},
        '{1'b0, 1'b0, 1'b0, 10'h041, 32'h0,        32'hC0DE0041, 2'd1, 2'd1},
        '{1'b0, 1'b0, 1'b0, 10'h009, 32'h0,        32'h11110009, 2'd1, 2'd0},
        '{1'b1, 1'b0, 1'b0, 10'h002, 32'h22220002, 32'h0,        2'd0, 2'd1},
        '{1'b0, 1'b0, 1'b0, 10'h002, 32'h0,        32'h22220002, 2'd1, 2'd0},
        '{1'b1, 1'b0, 1'b0, 10'h002, 32'h33330002, 32'h0,        2'd0, 2'd1},
        '{1'b0, 1'b0, 1'b0, 10'h002, 32'h0,        32'h33330002, 2'd0, 2'd0},
        '{1'b1, 1'b1, 1'b0, 10'h003, 32'h44440003, 32'h0,        2'd1, 2'd0},
        '{1'b0, 1'b0, 1'b0, 10'h003, 32'h0,        32'h44440003, 2'd0, 2'd0}
    };

    function automatic string vec_req(input int i, input vec_t v);
        if (i >= 5 && i <= 8)  return "R1";
        if (v.we && !v.wb)     return "R4";
        if (v.we || v.dwr != 0) return "R3";
        if (i >= 10)           return "R9";
        return "R2";
    endfunction

    initial begin
        logic [DW-1:0] rd;
        int lat, r0, w0;
        logic busy;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R12: reset state
        chk("R12 ready", 32'(req_ready), 32'd1);
        chk("R12 resp", 32'(resp_valid), 32'd0);
        chk("R12 memreq", 32'(mem_req), 32'd0);

        for (int i = 0; i < NV; i++) begin
            r0 = nrd; w0 = nwr;
            access(VEC[i].we, VEC[i].wb, VEC[i].msg, VEC[i].addr, VEC[i].wdata, rd, lat, busy);
            if (!VEC[i].we) chk({vec_req(i, VEC[i]), " data"}, rd, VEC[i].exp);
            chk({vec_req(i, VEC[i]), " mem reads"}, 32'(nrd - r0), 32'(VEC[i].drd));
            chk({vec_req(i, VEC[i]), " mem writes"}, 32'(nwr - w0), 32'(VEC[i].dwr));
            if (VEC[i].drd == 0 && VEC[i].dwr == 0)
                chk("R2 hit latency", 32'(lat), 32'd1);
            else
                chk("R11 busy during memory access", 32'(busy), 32'd1);
        end

        // R5/R6/R8/R7: set 4 with tagged and untagged, clean and dirty lines
        access(1'b0, 1'b0, 1'b1, 10'h004, 32'h0, rd, lat, busy);
        access(1'b0, 1'b0, 1'b0, 10'h00C, 32'h0, rd, lat, busy);
        access(1'b1, 1'b1, 1'b1, 10'h014, 32'h55550014, rd, lat, busy);
        access(1'b1, 1'b1, 1'b0, 10'h01C, 32'h6666001C, rd, lat, busy);
        r0 = nrd; w0 = nwr;
        pulse_inv();
        chk("R8 no write on invalidate", 32'(nwr - w0), 32'd0);
        access(1'b0, 1'b0, 1'b0, 10'h00C, 32'h0, rd, lat, busy);
        chk("R7 untagged still hits", 32'(nrd - r0), 32'd0);
        chk("R7 untagged data", rd, 32'hC0DE000C);
        access(1'b0, 1'b0, 1'b0, 10'h01C, 32'h0, rd, lat, busy);
        chk("R7 untagged dirty data", rd, 32'h6666001C);
        chk("R7 no read", 32'(nrd - r0), 32'd0);
        access(1'b0, 1'b0, 1'b1, 10'h004, 32'h0, rd, lat, busy);
        chk("R6 R5 tagged line misses", 32'(nrd - r0), 32'd1);
        access(1'b0, 1'b0, 1'b1, 10'h014, 32'h0, rd, lat, busy);
        chk("R6 tagged dirty line misses", 32'(nrd - r0), 32'd2);
        chk("R8 dropped dirty data", rd, 32'hC0DE0014);
        chk("R8 no write-back at all", 32'(nwr - w0), 32'd0);

        // R7: untagged dirty line still written back after an invalidate
        access(1'b1, 1'b1, 1'b0, 10'h005, 32'h77770005, rd, lat, busy);
        access(1'b0, 1'b0, 1'b0, 10'h00D, 32'h0, rd, lat, busy);
        access(1'b0, 1'b0, 1'b0, 10'h015, 32'h0, rd, lat, busy);
        access(1'b0, 1'b0, 1'b0, 10'h01D, 32'h0, rd, lat, busy);
        pulse_inv();
        r0 = nrd; w0 = nwr;
        access(1'b0, 1'b0, 1'b0, 10'h025, 32'h0, rd, lat, busy);
        chk("R7 dirty kept: eviction writes", 32'(nwr - w0), 32'd1);
        chk("R7 written value", mem[10'h005], 32'h77770005);
        chk("R9 fill data", rd, 32'hC0DE0025);

        // R10: invalidate in the cycle the fill completes
        arm_inv = 1'b1;
        access(1'b0, 1'b0, 1'b1, 10'h006, 32'h0, rd, lat, busy);
        arm_inv = 1'b0;
        chk("R10 data still returned", rd, 32'hC0DE0006);
        r0 = nrd;
        access(1'b0, 1'b0, 1'b1, 10'h006, 32'h0, rd, lat, busy);
        chk("R10 tagged fill ends invalid", 32'(nrd - r0), 32'd1);
        arm_inv = 1'b1;
        access(1'b0, 1'b0, 1'b0, 10'h00E, 32'h0, rd, lat, busy);
        arm_inv = 1'b0;
        r0 = nrd;
        access(1'b0, 1'b0, 1'b0, 10'h00E, 32'h0, rd, lat, busy);
        chk("R10 untagged fill stays valid", 32'(nrd - r0), 32'd0);
        chk("R10 untagged data", rd, 32'hC0DE000E);

        summary();
        $finish;
    end

endmodule